// File: doc/BRIEF.md
# Power Amplifier Enable Guard with Failsafe Timeout

This block turns the software power-amplifier request into the physical enable line of the amplifier. It takes the control byte that software writes, decodes the request bit and the two-bit operating mode, and drives the amplifier enable one clock later. While the mode is configuration, the request is held back. As soon as the mode moves to sync, data or test, a request that is already set takes effect.

An independent failsafe timer watches the physical enable. A prescaler derives a coarse tick from the clock frequency. A tick counter then trips after a set number of ticks of uninterrupted on-time. A trip forces the enable off and latches a timeout flag. The software-visible request bit is left alone. To arm the amplifier again, software must first clear the request bit, which also clears the flag, and then set it again. Any period with the output off restarts the timer from zero. The clock rate, the tick length and the tick count are parameters, so a bench can shrink the timeout to a few hundred cycles.

Top module: `pa_enable_guard`

## Requirements
- R1: Control byte bit 7 is the amplifier request (1 = on). Bits 1:0 are the mode: 00 configuration, 01 sync, 10 data, 11 test. With the request set and a non-configuration mode, `pa_on` rises on the clock edge after the byte is applied.
- R2: While the mode is 00, `pa_on` stays 0 even with bit 7 set. When the mode changes to a non-zero value with bit 7 still set, `pa_on` rises one edge later.
- R3: Changing the mode to 00 while the amplifier is on drops `pa_on` on the next edge.
- R4: Once `pa_on` has been 1 for exactly CLK_HZ*TICK_SECONDS*TIMEOUT_TICKS consecutive cycles, it drops on the next edge and `timeout_flag` becomes 1 on that same edge.
- R5: After a timeout, with bit 7 held at 1, `pa_on` stays 0 whatever the mode does.
- R6: Clearing bit 7 after a timeout clears `timeout_flag` on the next edge. A later setting of bit 7, in a non-configuration mode, raises `pa_on` one edge after that.
- R7: The timer restarts from zero whenever `pa_on` is 0. After an interruption, a full timeout period of on-time is needed again before a trip.
- R8: During and after reset, `pa_on` and `timeout_flag` are 0. A control byte of 0x00 drops `pa_on` on the next edge.
- R9: If bit 7 is cleared in the same cycle in which the timer expires, `pa_on` drops and `timeout_flag` stays 0.
- R10: Control byte bits 6:2 have no effect on `pa_on` or `timeout_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, also driven by a soft reset |
| ctrl_byte | input | 8 | Control register contents: bit 7 is the request, bits 1:0 are the mode |
| pa_on | output | 1 | Physical amplifier enable |
| timeout_flag | output | 1 | Failsafe timeout is latched |

## Verification
Two events can fall in the same cycle: the failsafe expiry and software clearing the request bit. The bench counts the on-time up to the final cycle before expiry and, in that cycle, writes a control byte with bit 7 low. The outcome is judged at the ports. The enable must drop on the next edge and the timeout flag must stay low, because the clear wins over the latch. The same run also checks that a plain expiry with the bit held does set the flag.

// File: rtl/pa_guard_pkg.sv
package pa_guard_pkg;

  typedef enum logic [1:0] {
    MODE_CFG  = 2'b00,
    MODE_SYNC = 2'b01,
    MODE_DATA = 2'b10,
    MODE_TEST = 2'b11
  } pa_mode_e;

  localparam int REQ_BIT = 7;

  // Clock cycles in one prescaler tick
  function automatic longint unsigned tick_cycles(longint unsigned clk_hz,
                                                  longint unsigned secs);
    return clk_hz * secs;
  endfunction

  // Width needed to count 0 .. n-1, never below one bit
  function automatic int count_width(longint unsigned n);
    int w;
    w = 1;
    while ((longint'(1) << w) < n) w++;
    return w;
  endfunction

  // Total on-time cycles until the failsafe trips
  function automatic longint unsigned trip_cycles(longint unsigned clk_hz,
                                                  longint unsigned secs,
                                                  longint unsigned ticks);
    return tick_cycles(clk_hz, secs) * ticks;
  endfunction

endpackage

// File: rtl/pa_guard_prescale.sv
module pa_guard_prescale #(
  parameter longint unsigned LIMIT = 64'd3000000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  import pa_guard_pkg::*;

  localparam int W = count_width(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 64'd1);

  logic [W-1:0] cyc_q;
  logic at_last;

  assign at_last = (cyc_q == LAST);
  assign tick    = run && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cyc_q <= '0;
    else if (at_last)   cyc_q <= '0;
    else                cyc_q <= cyc_q + 1'b1;
  end

  // R7
  prescale_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_q <= LAST);

  // R7
  prescale_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cyc_q == '0);

endmodule

// File: rtl/pa_guard_ticks.sv
module pa_guard_ticks #(
  parameter int TICKS = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic expire
);
  import pa_guard_pkg::*;

  localparam int W = count_width(longint'(TICKS) + 1);
  localparam logic [W-1:0] LAST = W'(TICKS - 1);

  logic [W-1:0] cnt_q;

  assign expire = tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt_q <= '0;
    else if (expire)    cnt_q <= '0;
    else if (tick)      cnt_q <= cnt_q + 1'b1;
  end

  // R4
  ticks_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R7
  ticks_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);

endmodule

// File: rtl/pa_guard_gate.sv
module pa_guard_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic mode_live,
  input  logic expire,
  output logic pa_on,
  output logic tripped
);

  logic grant;

  // Clearing the request outranks a simultaneous expiry
  always_ff @(posedge clk) begin
    if (!rst_n)      tripped <= 1'b0;
    else if (!req)   tripped <= 1'b0;
    else if (expire) tripped <= 1'b1;
  end

  assign grant = req && mode_live && !tripped && !expire;

  always_ff @(posedge clk) begin
    if (!rst_n) pa_on <= 1'b0;
    else        pa_on <= grant;
  end

  // R5
  trip_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tripped |-> !pa_on);

  // R4
  expire_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && req) |=> (tripped && !pa_on));

  // R6
  clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !tripped);

  // R9
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !req) |=> (!tripped && !pa_on));

  // R6
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pa_on) |-> ($past(req) && !$past(tripped)));

endmodule

// File: rtl/pa_enable_guard.sv
module pa_enable_guard #(
  parameter longint unsigned CLK_HZ        = 64'd50000000,
  parameter longint unsigned TICK_SECONDS  = 64'd60,
  parameter int              TIMEOUT_TICKS = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] ctrl_byte,
  output logic       pa_on,
  output logic       timeout_flag
);
  import pa_guard_pkg::*;

  localparam longint unsigned TICK_LEN = tick_cycles(CLK_HZ, TICK_SECONDS);

  pa_mode_e mode;
  logic     req;
  logic     mode_live;
  logic     tick;
  logic     expire;
  logic     unused_ctrl;

  assign mode        = pa_mode_e'(ctrl_byte[1:0]);
  assign req         = ctrl_byte[REQ_BIT];
  assign mode_live   = (mode != MODE_CFG);
  assign unused_ctrl = ^ctrl_byte[6:2];

  pa_guard_prescale #(.LIMIT(TICK_LEN)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (pa_on),
    .tick (tick)
  );

  pa_guard_ticks #(.TICKS(TIMEOUT_TICKS)) u_ticks (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (pa_on),
    .tick  (tick),
    .expire(expire)
  );

  pa_guard_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .mode_live(mode_live),
    .expire   (expire),
    .pa_on    (pa_on),
    .tripped  (timeout_flag)
  );

  // R2
  cfg_holds_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pa_on |-> $past(ctrl_byte[1:0]) != 2'b00);

  // R8
  zero_byte_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_byte == 8'h00) |=> !pa_on);

  // R1
  req_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_byte[7] |=> !pa_on);

endmodule

// File: tb/pa_enable_guard_tb_top.sv
module pa_enable_guard_tb_top;

  localparam longint unsigned T_HZ   = 64'd8;
  localparam longint unsigned T_SECS = 64'd2;
  localparam int              T_TICK = 15;
  localparam int              TRIP   = 8 * 2 * 15; // on-time cycles to trip

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ctrl_byte = 8'h00;
  logic       pa_on;
  logic       timeout_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  pa_enable_guard #(
    .CLK_HZ(T_HZ), .TICK_SECONDS(T_SECS), .TIMEOUT_TICKS(T_TICK)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_byte(ctrl_byte),
    .pa_on(pa_on), .timeout_flag(timeout_flag)
  );

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic exp_on,
                            input logic exp_flag);
    checks++;
    if (pa_on !== exp_on || timeout_flag !== exp_flag) begin
      errors++;
      $display("FAIL %s: pa_on=%b flag=%b expected pa_on=%b flag=%b",
               req, pa_on, timeout_flag, exp_on, exp_flag);
    end
  endtask

  task automatic go_idle();
    ctrl_byte = 8'h00;
    step(2);
  endtask

  task automatic t_reset();
    expect_out("R8 in reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    step(1);
    expect_out("R8 after reset", 1'b0, 1'b0);
  endtask

  task automatic t_modes();
    ctrl_byte = 8'h81; step(1);
    expect_out("R1 sync on", 1'b1, 1'b0);
    ctrl_byte = 8'h82; step(1);
    expect_out("R1 data on", 1'b1, 1'b0);
    ctrl_byte = 8'h83; step(1);
    expect_out("R1 test on", 1'b1, 1'b0);
    ctrl_byte = 8'h00; step(1);
    expect_out("R8 byte 0x00 off", 1'b0, 1'b0);
    ctrl_byte = 8'h03; step(1);
    expect_out("R1 no request", 1'b0, 1'b0);
    go_idle();
  endtask

  task automatic t_config();
    ctrl_byte = 8'h80; step(3);
    expect_out("R2 config held off", 1'b0, 1'b0);
    ctrl_byte = 8'h82; step(1);
    expect_out("R2 leave config", 1'b1, 1'b0);
    ctrl_byte = 8'h80; step(1);
    expect_out("R3 enter config", 1'b0, 1'b0);
    go_idle();
  endtask

  task automatic t_ignored();
    ctrl_byte = 8'h7C; step(2);
    expect_out("R10 high bits alone", 1'b0, 1'b0);
    ctrl_byte = 8'hFC; step(2);
    expect_out("R10 config with bits", 1'b0, 1'b0);
    ctrl_byte = 8'hFD; step(1);
    expect_out("R10 sync with bits", 1'b1, 1'b0);
    go_idle();
  endtask

  task automatic t_timeout();
    ctrl_byte = 8'h81; step(1);
    expect_out("R4 start", 1'b1, 1'b0);
    step(TRIP - 1);
    expect_out("R4 last on cycle", 1'b1, 1'b0);
    step(1);
    expect_out("R4 tripped", 1'b0, 1'b1);
    ctrl_byte = 8'h82; step(3);
    expect_out("R5 held off data", 1'b0, 1'b1);
    ctrl_byte = 8'h80; step(1);
    ctrl_byte = 8'h83; step(2);
    expect_out("R5 held off after config", 1'b0, 1'b1);
    ctrl_byte = 8'h03; step(1);
    expect_out("R6 flag cleared", 1'b0, 1'b0);
    ctrl_byte = 8'h83; step(1);
    expect_out("R6 rearmed", 1'b1, 1'b0);
    go_idle();
  endtask

  task automatic t_restart();
    ctrl_byte = 8'h81; step(TRIP - 10);
    expect_out("R7 before break", 1'b1, 1'b0);
    ctrl_byte = 8'h80; step(1);
    expect_out("R7 break", 1'b0, 1'b0);
    ctrl_byte = 8'h81; step(1);
    expect_out("R7 resumed", 1'b1, 1'b0);
    step(TRIP - 1);
    expect_out("R7 full period again", 1'b1, 1'b0);
    step(1);
    expect_out("R7 trip after restart", 1'b0, 1'b1);
    go_idle();
    expect_out("R6 idle clears flag", 1'b0, 1'b0);
  endtask

  task automatic t_same_cycle();
    ctrl_byte = 8'h82; step(1);
    step(TRIP - 1);
    expect_out("R9 last on cycle", 1'b1, 1'b0);
    ctrl_byte = 8'h02; step(1);
    expect_out("R9 clear beats expiry", 1'b0, 1'b0);
    ctrl_byte = 8'h82; step(1);
    expect_out("R9 on again at once", 1'b1, 1'b0);
    go_idle();
  endtask

  task automatic t_midrun_reset();
    ctrl_byte = 8'h81; step(1);
    expect_out("R8 on before reset", 1'b1, 1'b0);
    rst_n = 1'b0; step(1);
    expect_out("R8 reset drops", 1'b0, 1'b0);
    rst_n = 1'b1;
    go_idle();
  endtask

  initial begin
    step(3);
    t_reset();
    t_modes();
    t_config();
    t_ignored();
    t_timeout();
    t_restart();
    t_same_cycle();
    t_midrun_reset();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run incomplete, expected completion");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule